// File: doc/BRIEF.md
# Exception cause and interrupt status

This block is the control-register slice of a processor that records why the last exception happened and decides whether an interrupt request reaches the core. It holds a global interrupt enable and an eight-bit interrupt mask in a status word. It also holds a cause word. Some cause fields are loaded only when an exception is entered, some follow live inputs, and a few can be written by software with field-specific rules.

The pipeline pulses an exception-entry strobe together with the exception code, the branch-delay flag, the coprocessor number and the faulting instruction address. From that address the block forms the restart address. Interrupt lines, a timer request and a performance-counter overflow arrive as levels. A watch-trigger pulse is remembered if the core cannot take it at that moment, and it is requested again later.

Software reaches the block through a small select/write/read port. It can also use two single-cycle commands that clear or set the global enable and touch nothing else. When an external interrupt controller is in use, the block shows the level that controller supplies in place of the mirrored pins.

Top module: `exc_cause_ctl`

## Requirements
- R1: After reset the status word (select 0), cause word (select 1) and restart address (select 2) read 0, select 3 always reads 0, and `irq_req`, `count_stop`, `vec_sel` and `watch_req` are 0.
- R2: When `ext_mode` is 0, cause bits 15:10 follow `irq_pins[5:0]` in the same cycle, so pending interrupt k (2..7) is `irq_pins[k-2]`.
- R3: The status word holds the global enable at bit 0 and the mask at bits 15:8. When `ext_mode` is 0, `irq_req` is 1 exactly when the enable is 1 and some pending bit k (cause bits 15:8) has mask bit k set.
- R4: A pulse on `cmd_di` clears the global enable and a pulse on `cmd_ei` sets it, both on the next clock edge, and the mask is left unchanged. When both are given together, `cmd_di` wins.
- R5: Cause bits 9:8 are software interrupt requests. They are set or cleared by a write to the cause word and take part in the R3 request like the pins do.
- R6: Cause bit 27 is writable and drives `count_stop`. Cause bit 23 is writable and drives `vec_sel`.
- R7: Cause bit 22 is set when `watch_hit` pulses while `in_special_mode` is 1. A cause write with bit 22 at 0 clears it, and a write with bit 22 at 1 has no effect. `watch_req` is 1 while the bit is set and `in_special_mode` is 0. A watch hit while `in_special_mode` is 0 leaves the bit clear.
- R8: Cause writes leave bits 31, 30, 29:28, 26, 15:10 and 6:2 unchanged. All bits not named in these requirements read as 0.
- R9: On `exc_stb`, bit 31 loads `exc_bd`, bits 29:28 load `exc_cp`, and bits 6:2 load `exc_code`. The restart address becomes `exc_pc - 4` when `exc_bd` is 1, and `exc_pc` otherwise.
- R10: When `ext_mode` is 1, cause bits 15:10 show `ext_level`, and `irq_req` is 1 exactly when the enable is 1 and `ext_level` is non-zero.
- R11: Cause bit 30 follows `timer_irq` and bit 26 follows `perf_irq` live. Neither bit is writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pins | input | 6 | Hardware interrupt request levels, pending 7..2 |
| timer_irq | input | 1 | Timer interrupt level |
| perf_irq | input | 1 | Performance-counter overflow level |
| ext_mode | input | 1 | External interrupt controller mode |
| ext_level | input | 6 | Requested level from the external controller |
| exc_stb | input | 1 | Exception-entry strobe |
| exc_code | input | 5 | Exception code |
| exc_bd | input | 1 | Faulting instruction sits in a branch delay slot |
| exc_cp | input | 2 | Referenced coprocessor number |
| exc_pc | input | 32 | Faulting instruction address |
| watch_hit | input | 1 | Watch trigger pulse |
| in_special_mode | input | 1 | Core is in exception, error or debug mode |
| cmd_di | input | 1 | Clear global enable |
| cmd_ei | input | 1 | Set global enable |
| reg_sel | input | 2 | Register select: 0 status, 1 cause, 2 restart address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq_req | output | 1 | Interrupt request to the core |
| count_stop | output | 1 | Halt the external counter |
| vec_sel | output | 1 | Select the dedicated interrupt entry point |
| watch_req | output | 1 | Re-raised watch exception request |

## Verification
The bench builds the block with its default parameters: a 32-bit address path and a 4-byte instruction step. Under these values the restart address of a delay-slot exception is exactly four bytes below the faulting address, and this can be checked directly. With all six pins and both software bits present, the bench can mask single pending sources and show that the request gate lets through exactly the masked-in ones. It also exercises the external-controller switch-over with every pin held high, so the supplied level alone decides the request.

// File: rtl/exc_cause_pkg.sv
package exc_cause_pkg;
  localparam int DATA_W   = 32;
  localparam int HW_IRQ   = 6;
  localparam int SW_IRQ   = 2;
  localparam int NUM_IRQ  = HW_IRQ + SW_IRQ;
  localparam int CODE_W   = 5;
  localparam int CP_W     = 2;
  localparam int LVL_W    = 6;

  localparam int POS_BD   = 31;
  localparam int POS_TI   = 30;
  localparam int POS_CP   = 28;
  localparam int POS_DC   = 27;
  localparam int POS_PCI  = 26;
  localparam int POS_IV   = 23;
  localparam int POS_WP   = 22;
  localparam int POS_HW   = 10;
  localparam int POS_SW   = 8;
  localparam int POS_CODE = 2;
  localparam int POS_IE   = 0;
  localparam int POS_MASK = 8;

  typedef enum logic [1:0] {
    SEL_STATUS  = 2'd0,
    SEL_CAUSE   = 2'd1,
    SEL_RESTART = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  // Restart point: the branch before a delay slot, otherwise the faulting address
  function automatic logic [31:0] restart_point(input logic [31:0] pc,
                                                input logic in_slot,
                                                input logic [31:0] step);
    return in_slot ? (pc - step) : pc;
  endfunction

  // Request gate: any pending source that is masked in
  function automatic logic masked_any(input logic [NUM_IRQ-1:0] pend,
                                      input logic [NUM_IRQ-1:0] mask);
    return |(pend & mask);
  endfunction
endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import exc_cause_pkg::*;
(
  input  logic               glob_en,
  input  logic [NUM_IRQ-1:0] mask,
  input  logic [NUM_IRQ-1:0] pending,
  input  logic               ext_mode,
  input  logic [LVL_W-1:0]   ext_level,
  output logic               irq_req
);
  logic pin_path;
  logic ext_path;

  assign pin_path = masked_any(pending, mask);
  assign ext_path = |ext_level;
  assign irq_req  = glob_en & (ext_mode ? ext_path : pin_path);
endmodule

// File: rtl/watch_track.sv
module watch_track (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic in_special,
  input  logic clr_wr,
  output logic pend_q,
  output logic watch_req
);
  logic set_ev;

  assign set_ev = hit & in_special;

  always_ff @(posedge clk) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (set_ev) pend_q <= 1'b1;
    else if (clr_wr) pend_q <= 1'b0;
  end

  assign watch_req = pend_q & ~in_special;
endmodule

// File: rtl/cause_fields.sv
module cause_fields
  import exc_cause_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_stb,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              exc_bd,
  input  logic [CP_W-1:0]   exc_cp,
  input  logic [ADDR_W-1:0] exc_pc,
  input  logic              cause_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [CODE_W-1:0] code_q,
  output logic              bd_q,
  output logic [CP_W-1:0]   cp_q,
  output logic [ADDR_W-1:0] restart_q,
  output logic              dc_q,
  output logic              iv_q,
  output logic [SW_IRQ-1:0] sw_q
);
  localparam logic [31:0] STEP = 32'(INSN_BYTES);

  logic [31:0] pc_ext;
  logic [31:0] rp_full;

  assign pc_ext  = 32'(exc_pc);
  assign rp_full = restart_point(pc_ext, exc_bd, STEP);

  // Fields loaded only at exception entry
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q    <= '0;
      bd_q      <= 1'b0;
      cp_q      <= '0;
      restart_q <= '0;
    end else if (exc_stb) begin
      code_q    <= exc_code;
      bd_q      <= exc_bd;
      cp_q      <= exc_cp;
      restart_q <= rp_full[ADDR_W-1:0];
    end
  end

  // Software-writable fields
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dc_q <= 1'b0;
      iv_q <= 1'b0;
      sw_q <= '0;
    end else if (cause_we) begin
      dc_q <= wdata[POS_DC];
      iv_q <= wdata[POS_IV];
      sw_q <= wdata[POS_SW +: SW_IRQ];
    end
  end
endmodule

// File: rtl/exc_cause_ctl.sv
module exc_cause_ctl
  import exc_cause_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  irq_pins,
  input  logic        timer_irq,
  input  logic        perf_irq,
  input  logic        ext_mode,
  input  logic [5:0]  ext_level,
  input  logic        exc_stb,
  input  logic [4:0]  exc_code,
  input  logic        exc_bd,
  input  logic [1:0]  exc_cp,
  input  logic [31:0] exc_pc,
  input  logic        watch_hit,
  input  logic        in_special_mode,
  input  logic        cmd_di,
  input  logic        cmd_ei,
  input  logic [1:0]  reg_sel,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_req,
  output logic        count_stop,
  output logic        vec_sel,
  output logic        watch_req
);
  // Named internal events for the checker
  logic               status_wr;
  logic               cause_wr;
  logic               wp_clear_wr;
  logic               ie_q;
  logic [NUM_IRQ-1:0] mask_q;
  logic [NUM_IRQ-1:0] pending;
  logic [HW_IRQ-1:0]  hw_view;
  logic               wp_q;
  logic [CODE_W-1:0]  code_q;
  logic               bd_q;
  logic [CP_W-1:0]    cp_q;
  logic [ADDR_W-1:0]  restart_q;
  logic               dc_q;
  logic               iv_q;
  logic [SW_IRQ-1:0]  sw_q;
  logic [DATA_W-1:0]  cause_word;
  logic [DATA_W-1:0]  status_word;
  logic               unused_wdata;

  assign status_wr   = reg_we & (reg_sel == SEL_STATUS);
  assign cause_wr    = reg_we & (reg_sel == SEL_CAUSE);
  assign wp_clear_wr = cause_wr & ~reg_wdata[POS_WP];
  assign unused_wdata = ^reg_wdata;

  // Status: global enable and mask; commands own the enable bit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mask_q <= '0;
    end else begin
      if (status_wr) mask_q <= reg_wdata[POS_MASK +: NUM_IRQ];
      if (cmd_di)         ie_q <= 1'b0;
      else if (cmd_ei)    ie_q <= 1'b1;
      else if (status_wr) ie_q <= reg_wdata[POS_IE];
    end
  end

  cause_fields #(.ADDR_W(ADDR_W), .INSN_BYTES(INSN_BYTES)) u_fields (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_stb   (exc_stb),
    .exc_code  (exc_code),
    .exc_bd    (exc_bd),
    .exc_cp    (exc_cp),
    .exc_pc    (exc_pc[ADDR_W-1:0]),
    .cause_we  (cause_wr),
    .wdata     (reg_wdata),
    .code_q    (code_q),
    .bd_q      (bd_q),
    .cp_q      (cp_q),
    .restart_q (restart_q),
    .dc_q      (dc_q),
    .iv_q      (iv_q),
    .sw_q      (sw_q)
  );

  watch_track u_watch (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit        (watch_hit),
    .in_special (in_special_mode),
    .clr_wr     (wp_clear_wr),
    .pend_q     (wp_q),
    .watch_req  (watch_req)
  );

  assign hw_view = ext_mode ? ext_level : irq_pins;
  assign pending = {irq_pins, sw_q};

  irq_gate u_gate (
    .glob_en   (ie_q),
    .mask      (mask_q),
    .pending   (pending),
    .ext_mode  (ext_mode),
    .ext_level (ext_level),
    .irq_req   (irq_req)
  );

  always_comb begin
    cause_word                    = '0;
    cause_word[POS_BD]            = bd_q;
    cause_word[POS_TI]            = timer_irq;
    cause_word[POS_CP +: CP_W]    = cp_q;
    cause_word[POS_DC]            = dc_q;
    cause_word[POS_PCI]           = perf_irq;
    cause_word[POS_IV]            = iv_q;
    cause_word[POS_WP]            = wp_q;
    cause_word[POS_HW +: HW_IRQ]  = hw_view;
    cause_word[POS_SW +: SW_IRQ]  = sw_q;
    cause_word[POS_CODE +: CODE_W] = code_q;
  end

  always_comb begin
    status_word                      = '0;
    status_word[POS_IE]              = ie_q;
    status_word[POS_MASK +: NUM_IRQ] = mask_q;
  end

  always_comb begin
    unique case (reg_sel)
      SEL_STATUS:  reg_rdata = status_word;
      SEL_CAUSE:   reg_rdata = cause_word;
      SEL_RESTART: reg_rdata = 32'(restart_q);
      default:     reg_rdata = '0;
    endcase
  end

  assign count_stop = dc_q;
  assign vec_sel    = iv_q;
endmodule

// File: rtl/exc_cause_chk.sv
module exc_cause_chk
  import exc_cause_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_di,
  input logic               cmd_ei,
  input logic               status_wr,
  input logic               cause_wr,
  input logic [31:0]        reg_wdata,
  input logic               ie_q,
  input logic [NUM_IRQ-1:0] mask_q,
  input logic               wp_q,
  input logic [CODE_W-1:0]  code_q,
  input logic               exc_stb,
  input logic               watch_hit,
  input logic               in_special_mode,
  input logic               irq_req,
  input logic               count_stop,
  input logic               watch_req
);
  AST_DI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_di |=> !irq_req); // R4

  AST_CMD_KEEPS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_di || cmd_ei) && !status_wr) |=> $stable(mask_q)); // R4

  AST_NO_EN_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !irq_req); // R3

  AST_STOP_FOLLOWS_WR: assert property (@(posedge clk) disable iff (!rst_n)
    cause_wr |=> (count_stop == $past(reg_wdata[POS_DC]))); // R6

  AST_WP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_q && !(cause_wr && !reg_wdata[POS_WP])) |=> wp_q); // R7

  AST_WP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (watch_hit && in_special_mode) |=> wp_q); // R7

  AST_WATCH_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    watch_req |-> (wp_q && !in_special_mode)); // R7

  AST_CODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_stb |=> $stable(code_q)); // R8
endmodule

bind exc_cause_ctl exc_cause_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmd_di          (cmd_di),
  .cmd_ei          (cmd_ei),
  .status_wr       (status_wr),
  .cause_wr        (cause_wr),
  .reg_wdata       (reg_wdata),
  .ie_q            (ie_q),
  .mask_q          (mask_q),
  .wp_q            (wp_q),
  .code_q          (code_q),
  .exc_stb         (exc_stb),
  .watch_hit       (watch_hit),
  .in_special_mode (in_special_mode),
  .irq_req         (irq_req),
  .count_stop      (count_stop),
  .watch_req       (watch_req)
);

// File: tb/tb_exc_cause_ctl.sv
module tb_exc_cause_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  irq_pins = '0;
  logic        timer_irq = 1'b0;
  logic        perf_irq = 1'b0;
  logic        ext_mode = 1'b0;
  logic [5:0]  ext_level = '0;
  logic        exc_stb = 1'b0;
  logic [4:0]  exc_code = '0;
  logic        exc_bd = 1'b0;
  logic [1:0]  exc_cp = '0;
  logic [31:0] exc_pc = '0;
  logic        watch_hit = 1'b0;
  logic        in_special_mode = 1'b0;
  logic        cmd_di = 1'b0;
  logic        cmd_ei = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_req;
  logic        count_stop;
  logic        vec_sel;
  logic        watch_req;

  always #5 clk = ~clk;

  exc_cause_ctl dut (
    .clk(clk), .rst_n(rst_n), .irq_pins(irq_pins), .timer_irq(timer_irq),
    .perf_irq(perf_irq), .ext_mode(ext_mode), .ext_level(ext_level),
    .exc_stb(exc_stb), .exc_code(exc_code), .exc_bd(exc_bd), .exc_cp(exc_cp),
    .exc_pc(exc_pc), .watch_hit(watch_hit), .in_special_mode(in_special_mode),
    .cmd_di(cmd_di), .cmd_ei(cmd_ei), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .count_stop(count_stop), .vec_sel(vec_sel), .watch_req(watch_req)
  );

  // Observation kinds
  localparam int OBS_RDATA = 0;
  localparam int OBS_IRQ   = 1;
  localparam int OBS_STOP  = 2;
  localparam int OBS_VEC   = 3;
  localparam int OBS_WATCH = 4;

  typedef struct {
    int          what;
    logic [31:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // Cause word assembled from the requirement field positions
  function automatic logic [31:0] mk_cause(bit bd, bit ti, bit [1:0] cp, bit dc, bit pci,
                                           bit iv, bit wp, bit [5:0] hi, bit [1:0] sw,
                                           bit [4:0] code);
    logic [31:0] w;
    w = 32'h0;
    w = w | (32'(bd) << 31) | (32'(ti) << 30) | (32'(cp) << 28) | (32'(dc) << 27);
    w = w | (32'(pci) << 26) | (32'(iv) << 23) | (32'(wp) << 22);
    w = w | (32'(hi) << 10) | (32'(sw) << 8) | (32'(code) << 2);
    return w;
  endfunction

  function automatic logic [31:0] observe(int what);
    case (what)
      OBS_RDATA: return reg_rdata;
      OBS_IRQ:   return 32'(irq_req);
      OBS_STOP:  return 32'(count_stop);
      OBS_VEC:   return 32'(vec_sel);
      default:   return 32'(watch_req);
    endcase
  endfunction

  // Driver side: push expectations
  task automatic expect_out(int what, logic [31:0] exp, string tag);
    sb_item_t it;
    it.what = what; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    #1;
  endtask

  task automatic expect_reg(logic [1:0] sel, logic [31:0] exp, string tag);
    reg_sel = sel;
    #1;
    expect_out(OBS_RDATA, exp, tag);
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    reg_sel = sel; reg_we = 1'b1; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    sig = 1'b0;
  endtask

  // Monitor: pop and compare
  initial begin
    forever begin
      sb_item_t it;
      logic [31:0] act;
      wait (sb.size() != 0);
      it = sb.pop_front();
      act = observe(it.what);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  // Watchdog
  initial begin
    #20000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    expect_reg(2'd0, 32'h0, "R1 status");
    expect_reg(2'd1, 32'h0, "R1 cause");
    expect_reg(2'd2, 32'h0, "R1 restart");
    expect_reg(2'd3, 32'h0, "R1 select3");
    expect_out(OBS_IRQ, 0, "R1 irq");
    expect_out(OBS_STOP, 0, "R1 stop");
    expect_out(OBS_VEC, 0, "R1 vec");
    expect_out(OBS_WATCH, 0, "R1 watch");

    // R2: live pin mirror (pending 2,5,7)
    irq_pins = 6'b101001;
    expect_reg(2'd1, mk_cause(0,0,0,0,0,0,0,6'b101001,0,0), "R2 mirror");
    expect_out(OBS_IRQ, 0, "R3 enable off");

    // R3: masked gating
    wr(2'd0, 32'h0000_A401);
    expect_reg(2'd0, 32'h0000_A401, "R3 status readback");
    expect_out(OBS_IRQ, 1, "R3 masked in");
    wr(2'd0, 32'h0000_0801);
    expect_out(OBS_IRQ, 0, "R3 masked out");
    wr(2'd0, 32'h0000_FF00);
    expect_out(OBS_IRQ, 0, "R3 global gate");

    // R4: atomic enable commands
    pulse(cmd_ei);
    expect_out(OBS_IRQ, 1, "R4 ei");
    expect_reg(2'd0, 32'h0000_FF01, "R4 ei keeps mask");
    pulse(cmd_di);
    expect_out(OBS_IRQ, 0, "R4 di");
    expect_reg(2'd0, 32'h0000_FF00, "R4 di keeps mask");
    @(negedge clk);
    cmd_di = 1'b1; cmd_ei = 1'b1;
    @(negedge clk);
    cmd_di = 1'b0; cmd_ei = 1'b0;
    expect_reg(2'd0, 32'h0000_FF00, "R4 di wins");
    pulse(cmd_ei);

    // R5: software interrupts
    irq_pins = '0;
    #1;
    expect_out(OBS_IRQ, 0, "R5 idle");
    wr(2'd1, 32'h0000_0100);
    expect_out(OBS_IRQ, 1, "R5 sw request");
    expect_reg(2'd1, 32'h0000_0100, "R5 sw readback");
    wr(2'd1, 32'h0);
    expect_out(OBS_IRQ, 0, "R5 sw cleared");

    // R6: stop and vector select
    wr(2'd1, 32'h0880_0000);
    expect_out(OBS_STOP, 1, "R6 stop");
    expect_out(OBS_VEC, 1, "R6 vec");
    expect_reg(2'd1, 32'h0880_0000, "R6 readback");

    // R8: read-only fields ignore writes
    wr(2'd1, 32'hFFFF_FFFF);
    expect_reg(2'd1, mk_cause(0,0,0,1,0,1,0,0,2'b11,0), "R8 ro ignored");
    wr(2'd1, 32'h0);
    expect_out(OBS_STOP, 0, "R6 stop cleared");

    // R9: exception entry
    @(negedge clk);
    exc_stb = 1'b1; exc_code = 5'd11; exc_bd = 1'b1; exc_cp = 2'd2; exc_pc = 32'h0000_0100;
    @(negedge clk);
    exc_stb = 1'b0;
    expect_reg(2'd1, mk_cause(1,0,2'd2,0,0,0,0,0,0,5'd11), "R9 fields slot");
    expect_reg(2'd2, 32'h0000_00FC, "R9 restart slot");
    @(negedge clk);
    exc_stb = 1'b1; exc_code = 5'd4; exc_bd = 1'b0; exc_cp = 2'd1; exc_pc = 32'h0000_0200;
    @(negedge clk);
    exc_stb = 1'b0; exc_code = 5'd31; exc_cp = 2'd3; exc_pc = 32'hDEAD_0000;
    expect_reg(2'd1, mk_cause(0,0,2'd1,0,0,0,0,0,0,5'd4), "R9 fields plain");
    expect_reg(2'd2, 32'h0000_0200, "R9 restart plain");
    wr(2'd1, 32'hFFFF_FFFF);
    expect_reg(2'd1, mk_cause(0,0,2'd1,1,0,1,0,0,2'b11,5'd4), "R8 exc fields kept");
    wr(2'd1, 32'h0);

    // R7: watch pending
    pulse(watch_hit);
    expect_reg(2'd1, mk_cause(0,0,2'd1,0,0,0,0,0,0,5'd4), "R7 no set outside");
    in_special_mode = 1'b1;
    pulse(watch_hit);
    expect_reg(2'd1, mk_cause(0,0,2'd1,0,0,0,1,0,0,5'd4), "R7 set");
    expect_out(OBS_WATCH, 0, "R7 held in special");
    in_special_mode = 1'b0;
    #1;
    expect_out(OBS_WATCH, 1, "R7 re-raised");
    wr(2'd1, 32'h0040_0000);
    expect_reg(2'd1, mk_cause(0,0,2'd1,0,0,0,1,0,0,5'd4), "R7 write one ignored");
    wr(2'd1, 32'h0);
    expect_reg(2'd1, mk_cause(0,0,2'd1,0,0,0,0,0,0,5'd4), "R7 cleared");
    expect_out(OBS_WATCH, 0, "R7 request dropped");

    // R11: timer and perf flags
    timer_irq = 1'b1; perf_irq = 1'b1;
    expect_reg(2'd1, mk_cause(0,1,2'd1,0,1,0,0,0,0,5'd4), "R11 flags live");
    wr(2'd1, 32'h0);
    timer_irq = 1'b0; perf_irq = 1'b0;
    expect_reg(2'd1, mk_cause(0,0,2'd1,0,0,0,0,0,0,5'd4), "R11 flags follow");

    // R10: external controller mode
    ext_mode = 1'b1; ext_level = 6'h2A; irq_pins = 6'h3F;
    expect_reg(2'd1, mk_cause(0,0,2'd1,0,0,0,0,6'h2A,0,5'd4), "R10 level shown");
    expect_out(OBS_IRQ, 1, "R10 level request");
    ext_level = 6'h00;
    expect_out(OBS_IRQ, 0, "R10 zero level");

    @(negedge clk);
    wait (sb.size() == 0);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule